// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Code Select

This block sits between five dual-purpose pads and the clock synthesiser's frequency lookup. While power-on reset is held, the pads are inputs. The block samples them on every clock edge and keeps the last sample as a 5-bit strap word. When reset is released the sample freezes, and every pad's output enable rises so that the pads can carry buffered clocks. Later activity on the pads never reaches the strap word again.

The effective 5-bit frequency code normally equals the strap word. Control software writes a configuration byte, which the block sees as a one-cycle write strobe with the byte value. In that byte, bit 3 selects the code source. When bit 3 is 1, the code is taken from byte bits 2 and 7:4: bit 2 becomes code bit 4, and bits 7:4 become code bits 3:0. When bit 3 is 0, the code returns to the strap word. Bits 1:0 of the byte are ignored. The code register loads only on a write. The strap word is also brought out in the bit positions that the readback registers expect.

There is no data stream here. Every pin is a plain control or status level.

Top module: `strap_cfg_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pad_oe` is all zeros after that edge.
- R2: At every clock edge with `rst_n` high, `pad_oe` becomes all ones (bit i enables pad i).
- R3: At each edge with `rst_n` low, `strap_q` takes the value of `pad_in`, with bit i taken from pad i. So after reset is released, `strap_q` holds the pad levels seen at the last edge of reset.
- R4: Once `rst_n` is high, `strap_q` does not change, whatever `pad_in` does.
- R5: After reset is released and before any write, `freq_code` equals `strap_q`.
- R6: A write (`cfg_wr` high) with `cfg_byte[3]`=1 sets `freq_code` to {`cfg_byte[2]`, `cfg_byte[7:4]`} after that edge, with `cfg_byte[2]` as bit 4.
- R7: A write with `cfg_byte[3]`=0 sets `freq_code` to `strap_q` after that edge, whatever the other byte bits hold.
- R8: With `rst_n` high and `cfg_wr` low, `freq_code` holds its value, including while `pad_in` toggles.
- R9: `rdbk_hi` = {strap bit 3, strap bit 0, strap bit 2}, which are the readback bits 7, 6 and 5. `rdbk_lo` = {strap bit 4, strap bit 1}, which are the readback bits 4 and 2.
- R10: Asserting reset again recaptures the pads and makes `freq_code` follow `pad_in` while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | control clock |
| rst_n | input | 1 | power-on reset, active low, sampled on clk |
| pad_in | input | 5 | levels read back from the shared pads |
| cfg_wr | input | 1 | one-cycle strobe: configuration byte written |
| cfg_byte | input | 8 | value of the configuration byte being written |
| pad_oe | output | 5 | per-pad output enable, 1 = pad drives a clock |
| strap_q | output | 5 | latched strap word |
| freq_code | output | 5 | effective frequency select code |
| rdbk_hi | output | 3 | strap bits for readback bits 7:5 |
| rdbk_lo | output | 2 | strap bits for readback bits 4 and 2 |

## Verification
The properties assume that `rst_n`, `cfg_wr` and `cfg_byte` are synchronous to `clk` and stable around each rising edge. They also assume that `cfg_wr` is a level qualified on the same edge as the byte. The stimulus meets these assumptions by changing every input two nanoseconds after a rising edge and sampling the outputs at the same point. The stimulus also holds reset for at least two edges, so that the strap word is captured after a settled pad value. The pads are toggled only while the block is out of reset, or else deliberately during a re-reset.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int unsigned STRAP_W  = 5;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SRC_BIT  = 3;
  localparam int unsigned MSB_SRC  = 2;
  localparam int unsigned LOW_LSB  = 4;
  localparam int unsigned LOW_W    = STRAP_W - 1;

  typedef logic [STRAP_W-1:0] code_t;

  function automatic code_t byte_to_code(input logic [BYTE_W-1:0] b);
    return {b[MSB_SRC], b[LOW_LSB +: LOW_W]};
  endfunction
endpackage

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] strap_q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic cap_q;
    always_ff @(posedge clk) begin
      if (!rst_n) cap_q <= pad_in[i];
    end
    assign strap_q[i] = cap_q;
  end
endmodule

// File: rtl/pad_dir.sv
module pad_dir #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pad
    logic oe_q;
    always_ff @(posedge clk) begin
      if (!rst_n) oe_q <= 1'b0;
      else        oe_q <= 1'b1;
    end
    assign pad_oe[i] = oe_q;
  end
endmodule

// File: rtl/code_select.sv
module code_select
  import strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  code_t             pad_in,
  input  code_t             strap_q,
  input  logic              cfg_wr,
  input  logic [BYTE_W-1:0] cfg_byte,
  output code_t             freq_code
);
  code_t code_q;
  code_t code_d;

  always_comb begin
    code_d = code_q;
    if (cfg_wr) code_d = cfg_byte[SRC_BIT] ? byte_to_code(cfg_byte) : strap_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) code_q <= pad_in;
    else        code_q <= code_d;
  end

  assign freq_code = code_q;
endmodule

// File: rtl/strap_cfg_top.sv
module strap_cfg_top
  import strap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        pad_in,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_byte,
  output logic [4:0]        pad_oe,
  output logic [4:0]        strap_q,
  output logic [4:0]        freq_code,
  output logic [2:0]        rdbk_hi,
  output logic [1:0]        rdbk_lo
);
  code_t strap_w;

  strap_latch #(.W(STRAP_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .strap_q(strap_w)
  );

  pad_dir #(.W(STRAP_W)) u_dir (
    .clk(clk), .rst_n(rst_n), .pad_oe(pad_oe)
  );

  code_select u_sel (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .strap_q(strap_w),
    .cfg_wr(cfg_wr), .cfg_byte(cfg_byte), .freq_code(freq_code)
  );

  assign strap_q = strap_w;
  assign rdbk_hi = {strap_w[3], strap_w[0], strap_w[2]};
  assign rdbk_lo = {strap_w[4], strap_w[1]};
endmodule

// File: rtl/strap_cfg_chk.sv
module strap_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] pad_in,
  input logic       cfg_wr,
  input logic [7:0] cfg_byte,
  input logic [4:0] pad_oe,
  input logic [4:0] strap_q,
  input logic [4:0] freq_code
);
  // R1
  pads_input_in_reset_chk: assert property (@(posedge clk)
    !rst_n |=> pad_oe == 5'b0);

  // R2
  pads_output_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> pad_oe == 5'b11111);

  // R3
  strap_tracks_in_reset_chk: assert property (@(posedge clk)
    !rst_n |=> strap_q == $past(pad_in));

  // R4
  strap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(strap_q));

  // R6
  override_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_byte[3]) |=> freq_code == {$past(cfg_byte[2]), $past(cfg_byte[7:4])});

  // R7
  strap_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_byte[3]) |=> freq_code == strap_q);

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(freq_code));
endmodule

bind strap_cfg_top strap_cfg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
  .pad_oe(pad_oe), .strap_q(strap_q), .freq_code(freq_code)
);

// File: tb/strap_cfg_top_bench.sv
module strap_cfg_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] pad_in = 5'b11111;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_byte = 8'h00;
  logic [4:0] pad_oe, strap_q, freq_code;
  logic [2:0] rdbk_hi;
  logic [1:0] rdbk_lo;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strap_cfg_top u_strap_cfg_top (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .cfg_wr(cfg_wr), .cfg_byte(cfg_byte),
    .pad_oe(pad_oe), .strap_q(strap_q), .freq_code(freq_code),
    .rdbk_hi(rdbk_hi), .rdbk_lo(rdbk_lo)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    cfg_wr = 1'b1; cfg_byte = b;
    tick();
    cfg_wr = 1'b0; cfg_byte = ~b;
  endtask

  initial begin
    #2;
    for (int s = 0; s < 32; s++) begin
      logic [4:0] sv;
      sv = 5'(s);
      rst_n = 1'b0; pad_in = ~sv;
      tick();
      pad_in = sv;
      tick();
      chk("R1 oe in reset", {3'b0, pad_oe}, 8'h00);
      chk("R10 code follows pads in reset", {3'b0, freq_code}, {3'b0, sv});
      rst_n = 1'b1; pad_in = ~sv;
      tick();
      chk("R2 oe after reset", {3'b0, pad_oe}, 8'h1f);
      chk("R3 strap captured", {3'b0, strap_q}, {3'b0, sv});
      chk("R5 code from strap", {3'b0, freq_code}, {3'b0, sv});
      chk("R9 readback hi", {5'b0, rdbk_hi}, {5'b0, sv[3], sv[0], sv[2]});
      chk("R9 readback lo", {6'b0, rdbk_lo}, {6'b0, sv[4], sv[1]});
      for (int k = 0; k < 3; k++) begin
        pad_in = 5'(s * 7 + k * 11);
        tick();
      end
      chk("R4 strap frozen", {3'b0, strap_q}, {3'b0, sv});
      chk("R8 code holds", {3'b0, freq_code}, {3'b0, sv});
      if (s % 4 == 0) begin
        for (int c = 0; c < 32; c++) begin
          logic [4:0] cv;
          cv = 5'(c);
          write_byte({cv[3:0], 1'b1, cv[4], 2'(c)});
          chk("R6 override code", {3'b0, freq_code}, {3'b0, cv});
          pad_in = ~pad_in;
          tick();
          chk("R8 hold after write", {3'b0, freq_code}, {3'b0, cv});
        end
      end else begin
        write_byte({4'(s), 1'b1, 1'b1, 2'b00});
        chk("R6 override code", {3'b0, freq_code}, {3'b0, 1'b1, 4'(s)});
      end
      write_byte({~sv[3:0], 1'b0, ~sv[4], 2'b11});
      chk("R7 back to strap", {3'b0, freq_code}, {3'b0, sv});
      chk("R4 strap after writes", {3'b0, strap_q}, {3'b0, sv});
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule